// File: doc/BRIEF.md
# Shortened BCH Parity Encoder

This block protects a serial packet payload with a two-error-correcting BCH code built on the (63,51) mother code. A start pulse carries the payload length N in bits. The block then works out how many message blocks are needed so that none exceeds 51 bits. It also works out one common message length that every block shares. Payload bits stream in one per cycle under a valid/ready handshake. Each block's message bits pass straight through to the output while a 12-stage LFSR accumulates the parity. The twelve parity bits follow the block.

When the blocks times the common length exceeds N, the missing bits are zeros placed at the tail of the last block. Those zeros count in that block's parity. The output stream marks the first message bit of every block and the final parity bit of the packet. A serial divider computes the block count and block length before the first output bit, which takes a fixed 36 cycles after the start pulse.

Top module: `bch_short_enc`

## Requirements
- R1: Each block's parity is the remainder of x^12·m(x) modulo g(x) = x^12+x^10+x^8+x^5+x^4+x^3+1, where the first message bit of the block is the highest-order coefficient. The 12 remainder bits are emitted right after the block's message bits, with the x^11 coefficient first. Each block starts from a cleared remainder.
- R2: For a length N, the number of blocks is B = ceil(N/51). The output carries exactly B asserted out_sof_o bits per packet.
- R3: The common message length is K = ceil(N/B). The packet's output is exactly B·(K+12) valid bits, each block being K message bits followed by 12 parity bits.
- R4: The B·K−N pad bits are zeros emitted at the end of the last block. They enter that block's parity, and in_ready_o stays low while they are emitted.
- R5: out_sof_o is high together with out_valid_o on the first message bit of each block and on no other cycle.
- R6: out_last_o is high on the final parity bit of the last block only, and no output is valid in the cycle after it.
- R7: While payload bits remain, in_ready_o is high during message phases. An accepted input bit appears on out_bit_o with out_valid_o in the same cycle. A message-phase cycle without in_valid_i produces no output.
- R8: A start pulse while a packet is in progress is ignored. A start pulse carrying N = 0 is ignored and produces no output or input request.
- R9: During and directly after reset, out_valid_o and in_ready_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Packet start pulse, accepted when idle |
| len_i | input | 16 | Payload length N in bits, sampled with start_i |
| in_bit_i | input | 1 | Payload bit |
| in_valid_i | input | 1 | Payload bit valid |
| in_ready_o | output | 1 | Encoder accepts a payload bit |
| out_bit_o | output | 1 | Encoded stream bit |
| out_valid_o | output | 1 | Encoded bit valid |
| out_sof_o | output | 1 | First message bit of a block |
| out_last_o | output | 1 | Final parity bit of the packet |

## Verification
The assertions check several rules on every cycle. An accepted input bit must pass through unchanged in the same cycle. An idle input must give no output. Parity phases must stream without requesting input. Block-start and last flags must sit on valid, isolated cycles, and the computed block length must stay within 1 to 51. Some behaviours can only be shown by the bench scenarios, which compare every output bit against a long-division reference. These are the actual parity values, the block count and shared length for lengths that do and do not need padding, the position of the pad zeros, and that stray start pulses leave a packet untouched.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;
  localparam int LEN_W   = 16;
  localparam int MSG_MAX = 51;
  localparam int PAR_W   = 12;
  localparam logic [PAR_W-1:0] GEN_LOW = 12'h539;
  localparam int KW = $clog2(MSG_MAX + 1);
  localparam int PW = $clog2(PAR_W);
  localparam int DW = LEN_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIV1, ST_DIV2, ST_MSG, ST_PAR
  } enc_state_t;
endpackage

// File: rtl/bch_div.sv
module bch_div #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, rem_d, quo_q, quo_d, den_q, den_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic [W:0]    part, diff;
  logic          ge;

  assign part = {rem_q, quo_q[W-1]};
  assign ge   = part >= {1'b0, den_q};
  assign diff = part - {1'b0, den_q};

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    den_d  = den_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (go) begin
      rem_d = '0;
      quo_d = num;
      den_d = den;
      cnt_d = CW'(W);
    end else if (cnt_q != '0) begin
      rem_d  = ge ? diff[W-1:0] : part[W-1:0];
      quo_d  = {quo_q[W-2:0], ge};
      cnt_d  = cnt_q - 1'b1;
      done_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      den_q  <= den_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign quo  = quo_q;
  assign done = done_q;
endmodule

// File: rtl/bch_lfsr.sv
module bch_lfsr #(
  parameter int W = 12,
  parameter logic [W-1:0] POLY = 12'h539
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic feed,
  input  logic shift,
  input  logic din,
  output logic msb
);
  logic [W-1:0] r_q, r_d;
  logic         fb;

  assign fb = din ^ r_q[W-1];

  always_comb begin
    r_d = r_q;
    if (clr)        r_d = '0;
    else if (feed)  r_d = {r_q[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
    else if (shift) r_d = {r_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_q <= '0;
    else        r_q <= r_d;
  end

  assign msb = r_q[W-1];
endmodule

// File: rtl/bch_short_enc.sv
module bch_short_enc
  import bch_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             in_bit_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  output logic             out_bit_o,
  output logic             out_valid_o,
  output logic             out_sof_o,
  output logic             out_last_o
);
  enc_state_t       st_q, st_d;
  logic [LEN_W-1:0] n_q, n_d, taken_q, taken_d, left_q, left_d;
  logic [KW-1:0]    klen_q, klen_d, kcnt_q, kcnt_d;
  logic [PW-1:0]    pcnt_q, pcnt_d;
  logic             div_go, div_done;
  logic [DW-1:0]    div_num, div_den, div_quo;
  logic             msg_ph, par_ph, pad, fire, par_bit;

  assign msg_ph = (st_q == ST_MSG);
  assign par_ph = (st_q == ST_PAR);
  assign pad    = (taken_q == n_q);
  assign fire   = msg_ph && (pad || in_valid_i);

  assign div_go  = ((st_q == ST_IDLE) && start_i && (len_i != '0)) ||
                   ((st_q == ST_DIV1) && div_done);
  assign div_num = (st_q == ST_IDLE) ? ({1'b0, len_i} + DW'(MSG_MAX - 1))
                                     : ({1'b0, n_q} + div_quo - DW'(1));
  assign div_den = (st_q == ST_IDLE) ? DW'(MSG_MAX) : div_quo;

  bch_div #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num),
    .den(div_den), .quo(div_quo), .done(div_done)
  );

  bch_lfsr #(.W(PAR_W), .POLY(GEN_LOW)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .clr(div_go), .feed(fire),
    .shift(par_ph), .din(out_bit_o), .msb(par_bit)
  );

  always_comb begin
    st_d    = st_q;
    n_d     = n_q;
    taken_d = taken_q;
    left_d  = left_q;
    klen_d  = klen_q;
    kcnt_d  = kcnt_q;
    pcnt_d  = pcnt_q;
    case (st_q)
      ST_IDLE: if (div_go) begin
        n_d  = len_i;
        st_d = ST_DIV1;
      end
      ST_DIV1: if (div_done) begin
        left_d = div_quo[LEN_W-1:0];
        st_d   = ST_DIV2;
      end
      ST_DIV2: if (div_done) begin
        klen_d  = div_quo[KW-1:0];
        taken_d = '0;
        kcnt_d  = '0;
        st_d    = ST_MSG;
      end
      ST_MSG: if (fire) begin
        if (!pad) taken_d = taken_q + 1'b1;
        if (kcnt_q == klen_q - 1'b1) begin
          kcnt_d = '0;
          pcnt_d = '0;
          st_d   = ST_PAR;
        end else begin
          kcnt_d = kcnt_q + 1'b1;
        end
      end
      ST_PAR: begin
        pcnt_d = pcnt_q + 1'b1;
        if (pcnt_q == PW'(PAR_W - 1)) begin
          left_d = left_q - 1'b1;
          st_d   = (left_q == LEN_W'(1)) ? ST_IDLE : ST_MSG;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      n_q     <= '0;
      taken_q <= '0;
      left_q  <= '0;
      klen_q  <= '0;
      kcnt_q  <= '0;
      pcnt_q  <= '0;
    end else begin
      st_q    <= st_d;
      n_q     <= n_d;
      taken_q <= taken_d;
      left_q  <= left_d;
      klen_q  <= klen_d;
      kcnt_q  <= kcnt_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign in_ready_o  = msg_ph && !pad;
  assign out_valid_o = fire || par_ph;
  assign out_bit_o   = par_ph ? par_bit : (msg_ph && !pad && in_bit_i);
  assign out_sof_o   = fire && (kcnt_q == '0);
  assign out_last_o  = par_ph && (pcnt_q == PW'(PAR_W - 1)) &&
                       (left_q == LEN_W'(1));
endmodule

// File: rtl/bch_short_enc_chk.sv
module bch_short_enc_chk
  import bch_enc_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          in_bit_i,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          out_bit_o,
  input logic          out_valid_o,
  input logic          out_sof_o,
  input logic          out_last_o,
  input logic          msg_ph,
  input logic          par_ph,
  input logic [KW-1:0] klen_q
);
  p_accept_passes_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o && in_valid_i |-> out_valid_o && (out_bit_o == in_bit_i));

  p_no_input_no_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready_o && !in_valid_i |-> !out_valid_o);

  p_parity_streams_r1: assert property (@(posedge clk) disable iff (!rst_n)
    par_ph |-> out_valid_o && !in_ready_o);

  p_sof_on_message_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof_o |-> out_valid_o && msg_ph);

  p_sof_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof_o |=> !out_sof_o);

  p_last_ends_packet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last_o |=> !out_valid_o && !in_ready_o);

  p_block_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ph |-> (klen_q >= KW'(1)) && (klen_q <= KW'(MSG_MAX)));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_quiet_in_reset_r9: assert (!out_valid_o && !in_ready_o);
    end
  end
endmodule

bind bch_short_enc bch_short_enc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_bit_i(in_bit_i), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .out_bit_o(out_bit_o), .out_valid_o(out_valid_o),
  .out_sof_o(out_sof_o), .out_last_o(out_last_o), .msg_ph(msg_ph),
  .par_ph(par_ph), .klen_q(klen_q)
);

// File: tb/test_bch_short_enc.sv
module test_bch_short_enc;
  logic        clk = 1'b0;
  logic        rst_n, start_i, in_bit_i, in_valid_i;
  logic [15:0] len_i;
  logic        in_ready_o, out_bit_o, out_valid_o, out_sof_o, out_last_o;

  int checks = 0, fails = 0;
  logic [2:0] expq[$];
  int cur_n = 0, acc_cnt = 0, sof_seen = 0, cyc = 0;
  logic [12:0] obs = '0;
  logic done_flag = 1'b0;

  always #4 clk = ~clk;

  bch_short_enc i_bch_short_enc (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .in_bit_i(in_bit_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .out_bit_o(out_bit_o), .out_valid_o(out_valid_o), .out_sof_o(out_sof_o),
    .out_last_o(out_last_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // monitor: sample mid low phase, after the driver has settled
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (in_ready_o && !in_valid_i)
        chk(!out_valid_o, "R7 idle input gave output", out_valid_o, 0);
      if (out_valid_o) begin
        obs = {obs[11:0], out_bit_o};
        if (acc_cnt == cur_n)
          chk(!in_ready_o, "R4 ready while padding", in_ready_o, 0);
        if (expq.size() == 0) begin
          chk(0, "R3 unexpected output bit", 1, 0);
        end else begin
          logic [2:0] e;
          e = expq.pop_front();
          chk(out_bit_o == e[2], "R1 bit", out_bit_o, e[2]);
          chk(out_sof_o == e[1], "R5 sof", out_sof_o, e[1]);
          chk(out_last_o == e[0], "R6 last", out_last_o, e[0]);
        end
        if (out_sof_o) sof_seen++;
      end
      if (in_ready_o && in_valid_i) acc_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      done_flag = 1'b1;
      chk(0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  function automatic bit pay(int i, int seed);
    return ((i * 7 + seed * 3 + (i >> 2)) % 5) < 2;
  endfunction

  // reference: long division by 13-bit generator
  task automatic push_expected(input int n, input int seed, input int patt);
    int b, k;
    bit g[13];
    logic [12:0] gv;
    gv = 13'h1539;
    for (int t = 0; t < 13; t++) g[t] = gv[12 - t];
    b = (n + 50) / 51;
    k = (n + b - 1) / b;
    for (int blk = 0; blk < b; blk++) begin
      bit c[64];
      for (int j = 0; j < 64; j++) c[j] = 0;
      for (int j = 0; j < k; j++) begin
        int idx;
        idx = blk * k + j;
        c[j] = (idx < n) ? (patt == 0 ? 1'b0 : patt == 1 ? 1'b1 : pay(idx, seed)) : 1'b0;
        expq.push_back({c[j], j == 0, 1'b0});
      end
      for (int j = 0; j < k; j++)
        if (c[j]) for (int t = 0; t < 13; t++) c[j + t] ^= g[t];
      for (int t = 0; t < 12; t++)
        expq.push_back({c[k + t], 1'b0, (blk == b - 1) && (t == 11)});
    end
  endtask

  task automatic run_pkt(input int n, input int seed, input int patt,
                         input bit gaps, input bit stray);
    int idx, guard, b;
    b = (n + 50) / 51;
    push_expected(n, seed, patt);
    @(negedge clk);
    cur_n = n; acc_cnt = 0; sof_seen = 0;
    start_i = 1'b1; len_i = 16'(n);
    @(negedge clk);
    start_i = 1'b0; len_i = '0;
    idx = 0; guard = 0;
    while (idx < n && guard < 20000) begin
      @(negedge clk);
      guard++;
      start_i  = stray && (idx == 10);
      len_i    = stray ? 16'd5 : 16'd0;
      in_valid_i = !(gaps && (guard % 3 == 0));
      in_bit_i = patt == 0 ? 1'b0 : patt == 1 ? 1'b1 : pay(idx, seed);
      #2;
      if (in_ready_o && in_valid_i) idx++;
    end
    @(negedge clk);
    in_valid_i = 1'b0; start_i = 1'b0;
    guard = 0;
    while (expq.size() != 0 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R3 missing output bits", expq.size(), 0);
    chk(sof_seen == b, "R2 block count", sof_seen, b);
    expq.delete();
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; len_i = '0; in_bit_i = 1'b0; in_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid_o && !in_ready_o, "R9 reset outputs", out_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!out_valid_o && !in_ready_o, "R9 after reset", in_ready_o, 0);

    // R1: single one bit gives the generator remainder
    run_pkt(1, 0, 1, 0, 0);
    chk(obs == 13'h1539, "R1 known codeword", obs, 13'h1539);

    run_pkt(51, 1, 2, 0, 0);   // R2 one full block
    run_pkt(52, 2, 2, 0, 0);   // R3 two blocks of 26
    run_pkt(53, 3, 2, 1, 0);   // R4 one pad zero, R7 gaps
    run_pkt(103, 4, 1, 0, 0);  // R4 two pad zeros, all ones
    run_pkt(160, 5, 2, 1, 0);  // R2 four blocks of 40
    run_pkt(100, 6, 0, 0, 0);  // R1 zero payload, zero parity
    run_pkt(120, 7, 2, 0, 1);  // R8 stray start mid-packet

    // R8: zero length start is ignored
    @(negedge clk);
    start_i = 1'b1; len_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); #2;
      chk(!out_valid_o && !in_ready_o, "R8 zero length ignored", out_valid_o, 0);
    end

    done_flag = 1'b1;
    finish_run();
  end
endmodule